// File: doc/BRIEF.md
# Cubic Residue Distortion Corrector

This block removes the odd-order bending that an open-loop interstage amplifier adds to a pipelined converter's residue. It works entirely after the backend conversion: each valid cycle it takes one signed backend code, treats it as a fraction of full scale and adds the truncated inverse of a cubic distortion. That inverse is a third-power term weighted by a programmable coefficient p plus a fifth-power term weighted by three times p squared. Even-order terms are left alone.

The coefficient p stands for the amplifier's cubic coefficient divided by the cube of its nominal gain. It is loaded from outside through a small write port. The block forms 3·p² once, when p is committed, and holds both values in registers. A write is kept pending and is committed only when no sample is in flight, so every sample is corrected with one consistent pair of coefficients. The datapath is a five-stage pipeline with a valid flag beside the data. Products are rounded to nearest and the sum is clamped to the output width.

Top module: `resid_cubic_corr`

## Requirements
- R1: After a synchronous reset, `dout_valid` is 0, `dout` is 0 and the active coefficient is 0.
- R2: With x the input code taken as a signed fraction with DW-1 fraction bits, and rnd(v, s) = floor((v + 2^(s-1)) / 2^s), the powers are x2 = rnd(x·x, DW-1), x3 = rnd(x2·x, DW-1) and x5 = rnd(x3·x2, DW-1).
- R3: The coefficient is signed, PW bits wide, with PF fraction bits. q = rnd(3·p·p, PF), and the corrected code is x + rnd(p·x3, PF) + rnd(q·x5, PF).
- R4: A sample taken by the edge at which `din_valid` is 1 appears on `dout` with `dout_valid` = 1 right after the fourth edge that follows. `dout_valid` is 0 in every other cycle.
- R5: The corrected code is clamped to the signed OW-bit range. With the defaults (DW=12, OW=14, PW=16, PF=14) that range is -8192 to 8191.
- R6: A write (`cfg_we` = 1) stores `cfg_coef` as pending. The pending value becomes active at the first edge at which a write is pending, `din_valid` is 0 and none of the four pipeline stages before the output register holds a valid sample. Samples taken before that edge use the old coefficient.
- R7: When several writes arrive before a commit, only the last one is committed.
- R8: The value on `din` has no effect while `din_valid` is 0, and `dout` holds its last value while `dout_valid` is 0.
- R9: With the reset coefficient 0, `dout` equals the sign-extended input code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_valid | input | 1 | Input code is valid this cycle |
| din | input | DW | Signed backend code |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_coef | input | PW | Signed coefficient p, PF fraction bits |
| dout_valid | output | 1 | Corrected code is valid |
| dout | output | OW | Signed corrected code, clamped |

## Verification
The coefficient commit and the arrival or draining of samples can fall in the same cycle. When they do, the commit has to wait for a fully empty pipeline, and a write that coincides with an otherwise idle edge must not commit until the next idle edge. The bench provokes this in three ways: writes during unbroken streams, writes that land at the edge where the last sample leaves stage four, and random writes mixed with sparse valid input. It predicts the commit edge from its own record of the last four valid inputs and judges every output code against a polynomial model that uses the coefficient that model says was active.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  // Round to nearest (ties toward +inf) and shift right arithmetically.
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v,
                                                 input int unsigned sh);
    logic signed [63:0] half;
    half = 64'sd1 <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Fifth-order weight 3*p^2 in the coefficient's own fixed-point format.
  function automatic logic signed [63:0] fifth_weight(input logic signed [63:0] p,
                                                      input int unsigned frac);
    return rnd_shr(64'sd3 * p * p, frac);
  endfunction
endpackage

// File: rtl/rcc_coef_bank.sv
module rcc_coef_bank #(
  parameter int PW = 16,
  parameter int PF = 14,
  parameter int QW = 2 * PW - PF + 2,
  parameter logic signed [PW-1:0] P_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic signed [PW-1:0] cfg_coef,
  input  logic                 busy,
  output logic signed [PW-1:0] p_act,
  output logic signed [QW-1:0] q_act
);
  import rcc_pkg::*;

  logic                 pend;
  logic signed [PW-1:0] p_pend;
  logic                 commit;

  assign commit = pend && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      p_pend <= '0;
      p_act  <= P_INIT;
      q_act  <= QW'(fifth_weight(64'(P_INIT), PF));
    end else begin
      if (commit) begin
        p_act <= p_pend;
        q_act <= QW'(fifth_weight(64'(p_pend), PF));
        pend  <= 1'b0;
      end
      if (cfg_we) begin
        p_pend <= cfg_coef;
        pend   <= 1'b1;
      end
    end
  end

  // R6: active pair never moves while a sample is in flight
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(p_act) && $stable(q_act));
  // R6 / R7: an idle edge with a pending write commits the latest pending value
  a_r7_commit_latest: assert property (@(posedge clk) disable iff (rst)
    (pend && !busy) |=> (p_act == $past(p_pend)));
  // R3: 3p^2 is never negative
  a_r3_weight_nonneg: assert property (@(posedge clk) disable iff (rst)
    !q_act[QW-1]);
endmodule

// File: rtl/rcc_power_pipe.sv
module rcc_power_pipe #(
  parameter int DW = 12,
  parameter int XW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic signed [DW-1:0] in_d,
  output logic                 v3,
  output logic signed [DW-1:0] db3,
  output logic signed [XW-1:0] x3_3,
  output logic signed [XW-1:0] x5_3,
  output logic                 busy
);
  import rcc_pkg::*;
  localparam int unsigned FB = DW - 1;

  logic                 v1, v2;
  logic signed [DW-1:0] db1, db2;
  logic signed [XW-1:0] x2_1, x2_2, x3_2;
  logic signed [XW-1:0] sq_n, cu_n, qu_n;

  always_comb begin
    sq_n = XW'(rnd_shr(64'(in_d) * 64'(in_d), FB));
    cu_n = XW'(rnd_shr(64'(x2_1) * 64'(db1), FB));
    qu_n = XW'(rnd_shr(64'(x3_2) * 64'(x2_2), FB));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      db1 <= '0; db2 <= '0; db3 <= '0;
      x2_1 <= '0; x2_2 <= '0; x3_2 <= '0; x3_3 <= '0; x5_3 <= '0;
    end else begin
      v1 <= in_v;
      if (in_v) begin
        db1  <= in_d;
        x2_1 <= sq_n;
      end
      v2 <= v1;
      if (v1) begin
        db2  <= db1;
        x2_2 <= x2_1;
        x3_2 <= cu_n;
      end
      v3 <= v2;
      if (v2) begin
        db3  <= db2;
        x3_3 <= x3_2;
        x5_3 <= qu_n;
      end
    end
  end

  assign busy = v1 | v2 | v3;

  // R2: the rounded square of a code is never negative
  a_r2_square_nonneg: assert property (@(posedge clk) disable iff (rst)
    v1 |-> !x2_1[XW-1]);
  // R2: odd powers keep the sign of the code (or vanish)
  a_r2_cube_sign: assert property (@(posedge clk) disable iff (rst)
    (v2 && !db2[DW-1]) |-> !x3_2[XW-1]);
endmodule

// File: rtl/rcc_poly_sum.sv
module rcc_poly_sum #(
  parameter int DW = 12,
  parameter int XW = DW + 2,
  parameter int PW = 16,
  parameter int PF = 14,
  parameter int QW = 2 * PW - PF + 2,
  parameter int OW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v3,
  input  logic signed [DW-1:0] db3,
  input  logic signed [XW-1:0] x3_3,
  input  logic signed [XW-1:0] x5_3,
  input  logic signed [PW-1:0] p_act,
  input  logic signed [QW-1:0] q_act,
  output logic                 v5,
  output logic signed [OW-1:0] dout,
  output logic                 busy
);
  import rcc_pkg::*;
  localparam int TW = QW + XW - PF + 2;
  localparam logic signed [63:0] HI = (64'sd1 <<< (OW - 1)) - 64'sd1;
  localparam logic signed [63:0] LO = -(64'sd1 <<< (OW - 1));

  logic                 v4;
  logic signed [DW-1:0] db4;
  logic signed [TW-1:0] t3_4, t5_4, t3_n, t5_n;
  logic signed [63:0]   sum;
  logic signed [OW-1:0] clamped;

  always_comb begin
    t3_n = TW'(rnd_shr(64'(p_act) * 64'(x3_3), PF));
    t5_n = TW'(rnd_shr(64'(q_act) * 64'(x5_3), PF));
    sum  = 64'(db4) + 64'(t3_4) + 64'(t5_4);
    if (sum > HI)      clamped = OW'(HI);
    else if (sum < LO) clamped = OW'(LO);
    else               clamped = OW'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v4 <= 1'b0; v5 <= 1'b0;
      db4 <= '0; t3_4 <= '0; t5_4 <= '0; dout <= '0;
    end else begin
      v4 <= v3;
      if (v3) begin
        db4  <= db3;
        t3_4 <= t3_n;
        t5_4 <= t5_n;
      end
      v5 <= v4;
      if (v4) dout <= clamped;
    end
  end

  assign busy = v4;

  // R8: output code holds when no result is produced
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !v4 |=> $stable(dout));
  // R3: a zero code stays zero whatever the coefficient
  a_r3_zero_fixed: assert property (@(posedge clk) disable iff (rst)
    (v4 && db4 == '0) |=> (dout == '0));
endmodule

// File: rtl/resid_cubic_corr.sv
module resid_cubic_corr #(
  parameter int DW = 12,
  parameter int OW = DW + 2,
  parameter int PW = 16,
  parameter int PF = 14,
  parameter logic signed [PW-1:0] P_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din_valid,
  input  logic signed [DW-1:0] din,
  input  logic                 cfg_we,
  input  logic signed [PW-1:0] cfg_coef,
  output logic                 dout_valid,
  output logic signed [OW-1:0] dout
);
  localparam int XW = DW + 2;
  localparam int QW = 2 * PW - PF + 2;

  logic                 v3, busy_pw, busy_ps, busy;
  logic signed [DW-1:0] db3;
  logic signed [XW-1:0] x3_3, x5_3;
  logic signed [PW-1:0] p_act;
  logic signed [QW-1:0] q_act;

  assign busy = din_valid | busy_pw | busy_ps;

  rcc_coef_bank #(.PW(PW), .PF(PF), .QW(QW), .P_INIT(P_INIT)) u_coef (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_coef(cfg_coef),
    .busy(busy), .p_act(p_act), .q_act(q_act));

  rcc_power_pipe #(.DW(DW), .XW(XW)) u_pow (
    .clk(clk), .rst(rst), .in_v(din_valid), .in_d(din),
    .v3(v3), .db3(db3), .x3_3(x3_3), .x5_3(x5_3), .busy(busy_pw));

  rcc_poly_sum #(.DW(DW), .XW(XW), .PW(PW), .PF(PF), .QW(QW), .OW(OW)) u_sum (
    .clk(clk), .rst(rst), .v3(v3), .db3(db3), .x3_3(x3_3), .x5_3(x5_3),
    .p_act(p_act), .q_act(q_act), .v5(dout_valid), .dout(dout), .busy(busy_ps));

  // Edges since reset, so the latency check never looks before reset.
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R4: fixed five-register latency between input and output valid
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6) |-> (dout_valid == $past(din_valid, 5)));
  // R1: nothing valid in the first edge after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd0) |-> !dout_valid);
endmodule

// File: tb/sim_resid_cubic_corr.sv
module sim_resid_cubic_corr;
  localparam int DW = 12, OW = 14, PW = 16, PF = 14;
  localparam longint HI = (64'sd1 <<< (OW - 1)) - 1;
  localparam longint LO = -(64'sd1 <<< (OW - 1));

  logic clk = 1'b0, rst = 1'b1;
  logic din_valid = 1'b0, cfg_we = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic signed [PW-1:0] cfg_coef = '0;
  logic dout_valid;
  logic signed [OW-1:0] dout;

  always #4 clk = ~clk;

  resid_cubic_corr #(.DW(DW), .OW(OW), .PW(PW), .PF(PF)) u0 (
    .clk(clk), .rst(rst), .din_valid(din_valid), .din(din), .cfg_we(cfg_we),
    .cfg_coef(cfg_coef), .dout_valid(dout_valid), .dout(dout));

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R1";
  longint p_act_m = 0, p_pend_m = 0, last_d = 0;
  bit pend_m = 0;
  bit [3:0] hist = '0;
  bit exp_v[8];
  longint exp_d[8];

  function automatic longint rnd(longint v, int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  function automatic longint model(longint x, longint p);
    longint x2, x3, x5, q, s;
    x2 = rnd(x * x, DW - 1);
    x3 = rnd(x2 * x, DW - 1);
    x5 = rnd(x3 * x2, DW - 1);
    q  = rnd(3 * p * p, PF);
    s  = x + rnd(p * x3, PF) + rnd(q * x5, PF);
    if (s > HI) s = HI;
    if (s < LO) s = LO;
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // One clock: drive, let the edge happen, update model, then judge outputs.
  task automatic step(bit v, longint d, bit we, longint c);
    bit idle;
    int slot;
    @(negedge clk);
    din_valid = v; din = DW'(d); cfg_we = we; cfg_coef = PW'(c);
    @(posedge clk);
    cyc++;
    idle = !v && (hist == 4'b0);                 // R6 commit condition
    if (pend_m && idle) begin p_act_m = p_pend_m; pend_m = 0; end
    if (we) begin p_pend_m = longint'(signed'(PW'(c))); pend_m = 1; end  // R7
    hist = {hist[2:0], v};
    if (v) begin
      slot = (cyc + 4) % 8;
      exp_v[slot] = 1'b1;
      exp_d[slot] = model(longint'(signed'(DW'(d))), p_act_m);
    end
    #2;
    slot = cyc % 8;
    check("R4 valid timing", longint'(dout_valid), longint'(exp_v[slot]));
    if (exp_v[slot]) begin
      check(tag, longint'(dout), exp_d[slot]);
      last_d = exp_d[slot];
    end else begin
      check("R8 hold", longint'(dout), last_d);
    end
    exp_v[slot] = 1'b0;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(0, $urandom, 0, 0);
  endtask

  task automatic load(longint c);
    step(0, 0, 1, c);
    idle_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_d[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 reset valid", longint'(dout_valid), 0);
    check("R1 reset data", longint'(dout), 0);

    // R9: identity with the reset coefficient, extremes first
    tag = "R9";
    step(1, -2048, 0, 0); step(1, -1, 0, 0); step(1, 0, 0, 0);
    step(1, 1, 0, 0); step(1, 2047, 0, 0);
    for (int i = 0; i < 200; i++) step($urandom_range(0, 1), $urandom, 0, 0);
    idle_n(6);

    // R2: unit coefficient exposes every rounded power
    tag = "R2";
    load(16'sh4000);
    for (int i = 0; i < 300; i++) step(1, $urandom, 0, 0);
    idle_n(6);

    // R6: write during an unbroken stream, commit waits for drain
    tag = "R6";
    for (int i = 0; i < 10; i++) step(1, $urandom, (i == 3), 16'shE000);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);   // last sample leaves stage four
    step(0, 0, 1, 16'sh1000);                        // write on an idle edge
    step(1, 1500, 0, 0);                             // must still use the older value
    idle_n(6);
    for (int i = 0; i < 20; i++) step(1, $urandom, 0, 0);
    idle_n(6);

    // R7: several writes before commit, last one wins
    tag = "R7";
    for (int i = 0; i < 6; i++) step(1, $urandom, 1, 16'sh0800 + i * 16'sh0400);
    idle_n(6);
    for (int i = 0; i < 30; i++) step(1, $urandom, 0, 0);
    idle_n(6);

    // R5: clamping at both rails, both coefficient signs
    tag = "R5";
    load(16'sh7FFF);
    step(1, 2047, 0, 0); step(1, -2048, 0, 0); step(1, 1800, 0, 0);
    idle_n(6);
    check("R5 model rail hi", model(2047, 32767), HI);
    check("R5 model rail lo", model(-2048, 32767), LO);
    load(-16'sh8000);
    step(1, 2047, 0, 0); step(1, -2048, 0, 0); step(1, -1200, 0, 0);
    idle_n(6);

    // R8: garbage on din while not valid
    tag = "R8";
    for (int i = 0; i < 40; i++) step((i % 5) == 0, $urandom, 0, 0);
    idle_n(6);

    // R3: random mix of samples and coefficient writes
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      longint c;
      c = ($urandom_range(0, 3) == 0) ? longint'($urandom) : longint'($urandom_range(0, 16383)) - 8192;
      step($urandom_range(0, 9) < 6, $urandom, $urandom_range(0, 49) == 0, c);
    end
    idle_n(8);
    summary();
  end
endmodule